// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block holds wall-clock time and calendar date as packed-BCD bytes: seconds, minutes, hours, day of month, month, two-digit year and a day-of-week counter. A one-cycle `tick` enable, produced elsewhere from a 32.768 kHz reference divided down to one pulse per second, advances the seconds. A carry passes from seconds through minutes, hours, date and month to the year within the same clock edge. The hour byte carries its own format bit, so the clock can count either 00 to 23 or 1 to 12 with a PM flag. Month lengths follow the calendar, and February gains its 29th day in every year whose two-digit value is a multiple of four.

A host sets any field through a one-cycle write port. Reads go through a shadow buffer. Pulsing `snap` copies every live field into the buffer on one edge, and `rd_sel` then picks the byte that appears on the registered `rd_data`. A tick that lands while the host walks through the fields changes only the live registers, so the values the host reads always form one consistent instant.

Top module: `bcd_rtc_core`

## Requirements
- R1: Seconds (code 0) and minutes (code 1) count in BCD from 00 to 59. Seconds advance on each `tick`. When a field at 59 is advanced it returns to 00 and passes a carry to the next field.
- R2: When bit 7 of the hour byte (code 2) is 1, bits 5:0 count BCD hours 00 to 23. An hour carry at 23 returns the hours to 00, passes a carry to the date, and leaves bits 7:6 unchanged.
- R3: When bit 7 of the hour byte is 0, bits 4:0 hold BCD hours 01 to 12 and bit 5 is the PM flag (1 = PM). An hour carry at 11 gives 12 and flips PM. An hour carry at 12 gives 01 and keeps PM. Only the step from 11 PM to 12 AM passes a carry to the date.
- R4: Date (code 3) runs from 01 to the month length. Months 04, 06, 09 and 11 have 30 days, February has 28 days, and all other months have 31. A date carry at the month's last day gives 01 and advances the month (code 4). Month 12 wraps to 01 and advances the year (code 5). Year 99 wraps to 00.
- R5: A year value that is divisible by 4, including 00, gives February 29 days. Any other year value gives February 28 days.
- R6: The day-of-week counter (code 6, bits 2:0, upper bits 0) advances 0 to 6 and wraps to 0 on every date carry.
- R7: After a synchronous reset the fields read 00 seconds, 00 minutes, hour byte 8'h12 (12-hour format, 12 AM), date 01, month 01, year 00 and day of week 0.
- R8: A `snap` pulse copies all seven live fields into the shadow buffer at that edge. If a tick arrives in the same cycle, the buffer gets the values from before the tick. Without `snap` the buffer holds its contents. `rd_data` shows the buffer byte chosen by `rd_sel` one cycle after the selection is presented, and code 7 reads 8'h00.
- R9: A write (`wr_en` with `wr_sel` set to a field code) stores `wr_data` into that field at the next edge. For day of week only bits 2:0 are stored. The write overrides any tick or carry into that field, and no carry leaves the written field in that cycle.
- R10: A single tick at 23:59:59 on the last day of December in year 99 updates every field in one edge to 00:00:00, 01/01, year 00, with the day of week advanced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance enable, one cycle wide |
| wr_en | input | 1 | Host field write strobe |
| wr_sel | input | 3 | Field code for the write (0 sec … 6 day of week) |
| wr_data | input | 8 | BCD value to write |
| snap | input | 1 | Copy live fields into the shadow buffer |
| rd_sel | input | 3 | Field code to read from the shadow buffer |
| rd_data | output | 8 | Registered byte from the shadow buffer |

## Verification
Two collisions matter here. The first is a tick in the same cycle as a snapshot. The bench drives both in one cycle and expects the buffer to hold the pre-tick time, then takes a second snapshot and expects the advanced time. The second is a host write that meets a carry into the same field. The bench writes the minutes in the cycle where the seconds roll over from 59, and expects the written minutes, seconds at 00, and hours untouched. Constrained-random start times near the rollover points trigger both collisions again at random instants, and each result is compared against a bench model that uses integer arithmetic.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int FIELD_W = 8;
  localparam int NUM_FIELDS = 7;
  localparam int SEL_W = 3;

  typedef logic [FIELD_W-1:0] bcd_t;

  typedef enum logic [SEL_W-1:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_DATE = 3'd3,
    FLD_MON  = 3'd4,
    FLD_YEAR = 3'd5,
    FLD_DOW  = 3'd6,
    FLD_NONE = 3'd7
  } field_e;

  function automatic bcd_t bcd_inc(input bcd_t v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic year_is_leap(input bcd_t yr);
    logic [7:0] bin;
    bin = {4'b0, yr[7:4]} * 8'd10 + {4'b0, yr[3:0]};
    return (bin % 8'd4) == 8'd0;
  endfunction

  function automatic bcd_t month_len(input bcd_t mon, input bcd_t yr);
    case (mon)
      8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic wr_sec,
  input  logic wr_min,
  input  logic wr_hour,
  input  bcd_t wr_data,
  output bcd_t sec_q,
  output bcd_t min_q,
  output bcd_t hour_q,
  output logic day_carry
);
  logic sec_wrap, min_wrap, hr_wrap;
  bcd_t hour_d, inc24, inc12;

  assign sec_wrap = tick && !wr_sec && (sec_q >= 8'h59);
  assign min_wrap = sec_wrap && !wr_min && (min_q >= 8'h59);
  assign inc24 = bcd_inc({2'b00, hour_q[5:0]});
  assign inc12 = bcd_inc({3'b000, hour_q[4:0]});

  always_comb begin
    hour_d  = hour_q;
    hr_wrap = 1'b0;
    if (wr_hour) begin
      hour_d = wr_data;
    end else if (min_wrap) begin
      if (hour_q[7]) begin
        if (hour_q[5:0] >= 6'h23) begin
          hour_d  = {hour_q[7:6], 6'h00};
          hr_wrap = 1'b1;
        end else begin
          hour_d = {hour_q[7:6], 6'h00} | (inc24 & 8'h3F);
        end
      end else begin
        if (hour_q[4:0] == 5'h11) begin
          hour_d  = {hour_q[7:6], ~hour_q[5], 5'h12};
          hr_wrap = hour_q[5];
        end else if (hour_q[4:0] >= 5'h12) begin
          hour_d = {hour_q[7:5], 5'h01};
        end else begin
          hour_d = {hour_q[7:5], 5'h00} | (inc12 & 8'h1F);
        end
      end
    end
  end

  assign day_carry = hr_wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h12;
    end else begin
      if (wr_sec)      sec_q <= wr_data;
      else if (tick)   sec_q <= sec_wrap ? 8'h00 : bcd_inc(sec_q);
      if (wr_min)        min_q <= wr_data;
      else if (sec_wrap) min_q <= min_wrap ? 8'h00 : bcd_inc(min_q);
      hour_q <= hour_d;
    end
  end

  // R1: seconds at 59 return to 00 on a tick
  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_sec && sec_q == 8'h59) |=> (sec_q == 8'h00));

  // R9: a write lands in the seconds field regardless of tick
  p_sec_write_r9: assert property (@(posedge clk) disable iff (rst)
    wr_sec |=> (sec_q == $past(wr_data)));

  // R2: 24-hour wrap at 23
  p_hour24_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (min_wrap && !wr_hour && hour_q[7] && hour_q[5:0] == 6'h23) |=> (hour_q[5:0] == 6'h00));

  // R3: 11 to 12 flips the PM flag in 12-hour mode
  p_pm_flip_r3: assert property (@(posedge clk) disable iff (rst)
    (min_wrap && !wr_hour && !hour_q[7] && hour_q[4:0] == 5'h11) |=> (hour_q[5] != $past(hour_q[5])));
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic day_carry,
  input  logic wr_date,
  input  logic wr_mon,
  input  logic wr_year,
  input  logic wr_dow,
  input  bcd_t wr_data,
  output bcd_t date_q,
  output bcd_t mon_q,
  output bcd_t year_q,
  output bcd_t dow_q
);
  bcd_t last_day;
  logic date_wrap, mon_wrap;

  assign last_day  = month_len(mon_q, year_q);
  assign date_wrap = day_carry && !wr_date && (date_q >= last_day);
  assign mon_wrap  = date_wrap && !wr_mon && (mon_q >= 8'h12);

  always_ff @(posedge clk) begin
    if (rst) begin
      date_q <= 8'h01;
      mon_q  <= 8'h01;
      year_q <= 8'h00;
      dow_q  <= 8'h00;
    end else begin
      if (wr_date)        date_q <= wr_data;
      else if (day_carry) date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);
      if (wr_mon)         mon_q <= wr_data;
      else if (date_wrap) mon_q <= mon_wrap ? 8'h01 : bcd_inc(mon_q);
      if (wr_year)        year_q <= wr_data;
      else if (mon_wrap)  year_q <= (year_q >= 8'h99) ? 8'h00 : bcd_inc(year_q);
      if (wr_dow)         dow_q <= {5'b0, wr_data[2:0]};
      else if (day_carry) dow_q <= (dow_q >= 8'h06) ? 8'h00 : dow_q + 8'h01;
    end
  end

  // R6: day of week wraps from 6 to 0
  p_dow_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (day_carry && !wr_dow && dow_q == 8'h06) |=> (dow_q == 8'h00));

  // R5: leap February reaches day 29
  p_feb29_r5: assert property (@(posedge clk) disable iff (rst)
    (day_carry && !wr_date && mon_q == 8'h02 && date_q == 8'h28 && year_is_leap(year_q))
      |=> (date_q == 8'h29));

  // R4: the month advances only when the date wraps
  p_mon_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!wr_mon && !date_wrap) |=> $stable(mon_q));
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot #(
  parameter int NF = 7,
  parameter int W = 8,
  localparam int SEL_W = $clog2(NF + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            snap,
  input  logic [NF*W-1:0] live_flat,
  input  logic [SEL_W-1:0] rd_sel,
  output logic [W-1:0]    rd_data
);
  logic [W-1:0] shadow [NF];

  for (genvar i = 0; i < NF; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (rst)       shadow[i] <= '0;
      else if (snap) shadow[i] <= live_flat[i*W +: W];
    end

    // R8: snapshot copies the live byte at the edge
    p_snap_copy_r8: assert property (@(posedge clk) disable iff (rst)
      snap |=> (shadow[i] == $past(live_flat[i*W +: W])));

    // R8: without snap the buffer keeps its byte
    p_snap_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !snap |=> (shadow[i] == $past(shadow[i])));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      rd_data <= '0;
      for (int i = 0; i < NF; i++)
        if (rd_sel == SEL_W'(i)) rd_data <= shadow[i];
    end
  end
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       snap,
  input  logic [2:0] rd_sel,
  output logic [7:0] rd_data
);
  logic [NUM_FIELDS-1:0] wr_hit;
  bcd_t sec_q, min_q, hour_q, date_q, mon_q, year_q, dow_q;
  logic day_carry;
  logic [NUM_FIELDS*FIELD_W-1:0] live_flat;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_dec
    assign wr_hit[f] = wr_en && (wr_sel == SEL_W'(f));
  end

  rtc_time_chain u_time (
    .clk(clk), .rst(rst), .tick(tick),
    .wr_sec(wr_hit[FLD_SEC]), .wr_min(wr_hit[FLD_MIN]), .wr_hour(wr_hit[FLD_HOUR]),
    .wr_data(wr_data),
    .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q), .day_carry(day_carry)
  );

  rtc_date_chain u_date (
    .clk(clk), .rst(rst), .day_carry(day_carry),
    .wr_date(wr_hit[FLD_DATE]), .wr_mon(wr_hit[FLD_MON]),
    .wr_year(wr_hit[FLD_YEAR]), .wr_dow(wr_hit[FLD_DOW]),
    .wr_data(wr_data),
    .date_q(date_q), .mon_q(mon_q), .year_q(year_q), .dow_q(dow_q)
  );

  assign live_flat = {dow_q, year_q, mon_q, date_q, hour_q, min_q, sec_q};

  rtc_snapshot #(.NF(NUM_FIELDS), .W(FIELD_W)) u_snap (
    .clk(clk), .rst(rst), .snap(snap), .live_flat(live_flat),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  // R8: the unused field code reads as zero
  p_rd_none_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == 3'd7) |=> (rd_data == 8'h00));

  // R9: a minute write in the seconds rollover cycle keeps the hour
  p_wr_blocks_carry_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_hit[FLD_MIN] && !wr_hit[FLD_HOUR]) |=> $stable(hour_q));
endmodule

// File: tb/tb_bcd_rtc_core.sv
module tb_bcd_rtc_core;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1, tick = 0, wr_en = 0, snap = 0;
  logic [2:0] wr_sel = 0, rd_sel = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [7:0] m [7];
  logic [7:0] img [7];

  bcd_rtc_core dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int b2i(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] i2b(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic int mdays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic void model_step(bit tk, bit we, int sel, logic [7:0] d);
    bit wr [7];
    logic [7:0] n [7];
    logic [7:0] t;
    int s, mi, h, dd, mo, y, w, dim;
    bit m24, pm, cs, cm, ch, cd, cmo;
    for (int k = 0; k < 7; k++) begin wr[k] = we && (sel == k); n[k] = m[k]; end
    s = b2i(m[0]); mi = b2i(m[1]); m24 = m[2][7]; pm = m[2][5];
    h = m24 ? b2i({2'b0, m[2][5:0]}) : b2i({3'b0, m[2][4:0]});
    dd = b2i(m[3]); mo = b2i(m[4]); y = b2i(m[5]); w = int'(m[6]);
    cs = tk && !wr[0] && s == 59;
    cm = cs && !wr[1] && mi == 59;
    ch = 0;
    if (wr[0]) n[0] = d; else if (tk) n[0] = i2b(s == 59 ? 0 : s + 1);
    if (wr[1]) n[1] = d; else if (cs) n[1] = i2b(mi == 59 ? 0 : mi + 1);
    if (wr[2]) n[2] = d;
    else if (cm) begin
      if (m24) begin
        ch = (h == 23); t = i2b(ch ? 0 : h + 1);
        n[2] = {m[2][7:6], t[5:0]};
      end else if (h == 11) begin
        ch = pm; n[2] = {m[2][7:6], ~pm, 5'h12};
      end else if (h == 12) begin
        n[2] = {m[2][7:5], 5'h01};
      end else begin
        t = i2b(h + 1); n[2] = {m[2][7:5], t[4:0]};
      end
    end
    dim = mdays(mo, y);
    cd  = ch && !wr[3] && dd >= dim;
    cmo = cd && !wr[4] && mo >= 12;
    if (wr[3]) n[3] = d; else if (ch) n[3] = i2b(cd ? 1 : dd + 1);
    if (wr[4]) n[4] = d; else if (cd) n[4] = i2b(cmo ? 1 : mo + 1);
    if (wr[5]) n[5] = d; else if (cmo) n[5] = i2b(y >= 99 ? 0 : y + 1);
    if (wr[6]) n[6] = {5'b0, d[2:0]}; else if (ch) n[6] = 8'(w >= 6 ? 0 : w + 1);
    for (int k = 0; k < 7; k++) m[k] = n[k];
  endfunction

  task automatic chk(logic [7:0] act, logic [7:0] exp, string tag, int fld);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s field %0d got %h expected %h", tag, fld, act, exp);
    end
  endtask

  task automatic cyc(bit tk, bit we, int sel, logic [7:0] d, bit sn);
    tick = tk; wr_en = we; wr_sel = sel[2:0]; wr_data = d; snap = sn;
    if (sn) for (int k = 0; k < 7; k++) img[k] = m[k];
    @(posedge clk); #1;
    model_step(tk, we, sel, d);
    tick = 0; wr_en = 0; snap = 0;
  endtask

  task automatic read_buf(string tag);
    for (int s = 0; s < 8; s++) begin
      rd_sel = s[2:0];
      @(posedge clk); #1;
      chk(rd_data, (s < 7) ? img[s] : 8'h00, tag, s);
    end
  endtask

  task automatic read_all(string tag);
    cyc(0, 0, 0, 0, 1);
    read_buf(tag);
  endtask

  task automatic set_all(logic [7:0] h, logic [7:0] mi, logic [7:0] s,
                         logic [7:0] d, logic [7:0] mo, logic [7:0] y, logic [7:0] w);
    cyc(0, 1, 0, s, 0); cyc(0, 1, 1, mi, 0); cyc(0, 1, 2, h, 0);
    cyc(0, 1, 3, d, 0); cyc(0, 1, 4, mo, 0); cyc(0, 1, 5, y, 0); cyc(0, 1, 6, w, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired R1 got timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED_1234);
    m = '{8'h00, 8'h00, 8'h12, 8'h01, 8'h01, 8'h00, 8'h00};
    repeat (3) @(posedge clk);
    #1 rst = 0;
    read_all("R7");

    // R10 R2 R4 R6: full ripple from seconds to year in 24h mode
    set_all(8'h80 | 8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99, 8'h06);
    cyc(1, 0, 0, 0, 0);
    read_all("R10");
    nchk++; if (m[0] !== 8'h00 || m[5] !== 8'h00 || m[6] !== 8'h00) begin nerr++;
      $display("FAIL R10 model got %h/%h/%h expected 00/00/00", m[0], m[5], m[6]); end

    // R3: 11:59:59 PM -> 12 AM next day
    set_all(8'h31, 8'h59, 8'h59, 8'h15, 8'h06, 8'h10, 8'h02);
    cyc(1, 0, 0, 0, 0);
    read_all("R3");
    // R3: 11:59:59 AM -> 12 PM same day
    set_all(8'h11, 8'h59, 8'h59, 8'h15, 8'h06, 8'h10, 8'h02);
    cyc(1, 0, 0, 0, 0);
    read_all("R3");
    // R3: 12:59:59 PM -> 1 PM
    set_all(8'h32, 8'h59, 8'h59, 8'h15, 8'h06, 8'h10, 8'h02);
    cyc(1, 0, 0, 0, 0);
    read_all("R3");

    // R5: leap year 24, then 29th rolls to March; non-leap 23; year 00
    set_all(8'hA3, 8'h59, 8'h59, 8'h28, 8'h02, 8'h24, 8'h00);
    cyc(1, 0, 0, 0, 0);
    read_all("R5");
    cyc(0, 1, 2, 8'hA3, 0); cyc(0, 1, 1, 8'h59, 0); cyc(0, 1, 0, 8'h59, 0);
    cyc(1, 0, 0, 0, 0);
    read_all("R5");
    set_all(8'hA3, 8'h59, 8'h59, 8'h28, 8'h02, 8'h23, 8'h00);
    cyc(1, 0, 0, 0, 0);
    read_all("R5");
    set_all(8'hA3, 8'h59, 8'h59, 8'h28, 8'h02, 8'h00, 8'h00);
    cyc(1, 0, 0, 0, 0);
    read_all("R5");

    // R4: 30-day month end
    set_all(8'hA3, 8'h59, 8'h59, 8'h30, 8'h04, 8'h50, 8'h03);
    cyc(1, 0, 0, 0, 0);
    read_all("R4");

    // R1: minute rollover into hour
    set_all(8'h85, 8'h59, 8'h58, 8'h10, 8'h10, 8'h10, 8'h01);
    cyc(1, 0, 0, 0, 0); cyc(1, 0, 0, 0, 0);
    read_all("R1");

    // R8: snapshot and tick in one cycle holds pre-tick time
    set_all(8'h89, 8'h59, 8'h59, 8'h10, 8'h10, 8'h10, 8'h01);
    cyc(1, 0, 0, 0, 1);
    read_buf("R8");
    read_all("R8");

    // R9: minute write collides with seconds carry; dow keeps 3 bits
    set_all(8'h89, 8'h59, 8'h59, 8'h10, 8'h10, 8'h10, 8'h01);
    cyc(1, 1, 1, 8'h30, 0);
    cyc(0, 1, 6, 8'hFD, 0);
    read_all("R9");

    // R6: dow wrap via midnight in 12h mode
    set_all(8'h31, 8'h59, 8'h59, 8'h05, 8'h05, 8'h05, 8'h06);
    cyc(1, 0, 0, 0, 0);
    read_all("R6");

    // Constrained random rounds
    for (int r = 0; r < 30; r++) begin
      int hh, mo, y, nt;
      logic [7:0] hb, tb8;
      bit md, pm;
      md = $urandom_range(0, 1);
      if (md) begin
        hh = $urandom_range(0, 23); tb8 = i2b(hh); hb = {2'b10, tb8[5:0]};
      end else begin
        hh = $urandom_range(1, 12); pm = $urandom_range(0, 1);
        tb8 = i2b(hh); hb = {2'b00, pm, tb8[4:0]};
      end
      mo = $urandom_range(1, 12); y = $urandom_range(0, 99);
      set_all(hb, ($urandom_range(0, 1) != 0) ? 8'h59 : i2b($urandom_range(0, 59)),
              i2b($urandom_range(40, 59)), i2b(mdays(mo, y) - int'($urandom_range(0, 1))),
              i2b(mo), i2b(y), 8'($urandom_range(0, 6)));
      nt = $urandom_range(1, 3000);
      for (int k = 0; k < nt; k++) begin
        if ($urandom_range(0, 63) == 0) begin
          cyc(1, 0, 0, 0, 1);
          read_buf("R8");
        end else if ($urandom_range(0, 127) == 0) begin
          cyc(1, 1, $urandom_range(0, 1), i2b($urandom_range(0, 59)), 0);
        end else begin
          cyc($urandom_range(0, 7) != 0, 0, 0, 0, 0);
        end
      end
      read_all(md ? "R2" : "R3");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule